// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is an interval timer on a small word-addressed register bus. A counter is loaded with a period value and counts down by one on every clock while it runs. When it expires it raises a sticky timeout flag, which becomes an interrupt if the interrupt enable is set. In continuous mode the counter reloads itself and keeps running. In one-shot mode it reloads and stops. The period is split across two 16-bit halves. Writing either half always forces the counter to reload. Software uses this to bring the next expiry in line with its own timing loop.

Two build-time switches shape the block. `WRITABLE_PERIOD` decides whether software can set the period or whether a fixed constant is always used. `HAS_STARTSTOP` decides whether period writes and the STOP bit can halt the counter. The core is a two-state machine with the states `ST_IDLE` (stopped) and `ST_RUN` (counting). It has these transitions:
- *start*: `ST_IDLE`→`ST_RUN` on a control write with START set and STOP clear.
- *halt*: `ST_RUN`→`ST_IDLE` on a control write with STOP set.
- *one-shot end*: `ST_RUN`→`ST_IDLE` on expiry with CONT clear.
- *period halt*: any state→`ST_IDLE` on a period write, only when start/stop control is built in.

Top module: `itimer`

## Requirements
- R1: After reset with start/stop control built in, the counter is stopped, status and control read 0 and `irq` is 0. Without start/stop control, the counter is running from reset with the build-time period loaded.
- R2: Register map by `bus_addr`: 0 is status (bit 0 = timeout flag TO, bit 1 = RUN). 1 is control (bit 0 = ITO interrupt enable, bit 1 = CONT, bit 2 = START, bit 3 = STOP; only ITO and CONT read back). 2 is period bits 15:0 and 3 is period bits 31:16. A read is taken on the edge where `bus_sel`=1 and `bus_wr`=0, and `bus_rdata` holds the result from the next cycle. Unused bits read 0.
- R3: With period P loaded and the counter stopped, a START write on edge e makes TO become 1 on edge e+P+1.
- R4: With CONT clear, expiry stops the counter (RUN reads 0) and reloads it with the period.
- R5: With CONT set, the counter reloads on expiry and keeps running, so it expires every P+1 edges.
- R6: A START write while the counter is running leaves the count untouched, so the next expiry happens on schedule.
- R7: With start/stop control built in, a write to either period half loads the counter with the new period and stops it.
- R8: Without start/stop control, a period write reloads the counter but does not stop it, and STOP writes have no effect.
- R9: With a fixed period, period write data is ignored. Both halves read back the build-time constant, and every reload uses that constant.
- R10: A STOP write halts the counter and holds its count. When START and STOP are written together, STOP wins.
- R11: `irq` is 1 exactly when TO is 1 and ITO is 1. Any write to status clears TO, unless an expiry happens on the same edge, in which case TO stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| irq | output | 1 | Timeout interrupt |

## Verification
The countdown is driven in four patterns, and each one separates the right behaviour from a plausible wrong one:
- A one-shot run from a stopped counter pins the exact P+1 latency and shows that the counter stops afterwards.
- A continuous run shows that the counter reloads and that the spacing between expiries stays the same.
- A START written part-way through a count must not move the next expiry; a design that reloads on START would expire four cycles late.
- Period writes are tried in both builds. In the default build the write must stop the counter. In the fixed, free-running build it must restart the full constant period, ignore the written data and leave the counter running.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_CTRL   = 2'd1,
        REG_PLO    = 2'd2,
        REG_PHI    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    localparam int B_TO    = 0;
    localparam int B_RUN   = 1;
    localparam int B_ITO   = 0;
    localparam int B_CONT  = 1;
    localparam int B_START = 2;
    localparam int B_STOP  = 3;
endpackage

// File: rtl/itimer_regs.sv
module itimer_regs
    import itimer_pkg::*;
#(
    parameter int unsigned        HALF_W          = 16,
    parameter bit                 WRITABLE_PERIOD = 1'b1,
    parameter bit                 HAS_STARTSTOP   = 1'b1,
    parameter logic [2*HALF_W-1:0] FIXED_PERIOD   = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  wr,
    input  logic [1:0]            addr,
    input  logic [HALF_W-1:0]     wdata,
    output logic [HALF_W-1:0]     rdata,
    input  logic                  expire,
    input  logic                  running,
    output logic [2*HALF_W-1:0]   period_val,
    output logic [2*HALF_W-1:0]   reload_val,
    output logic                  ito,
    output logic                  cont,
    output logic                  start_evt,
    output logic                  stop_evt,
    output logic                  reload_evt,
    output logic                  status_wr,
    output logic                  to_flag,
    output logic                  irq
);
    localparam int unsigned PERIOD_W = 2 * HALF_W;

    logic              wr_hit;
    logic              ctrl_wr;
    logic              ito_q, cont_q, to_q;
    logic [HALF_W-1:0] rd_mux, rdata_q;

    assign wr_hit     = sel && wr;
    assign status_wr  = wr_hit && (addr == REG_STATUS);
    assign ctrl_wr    = wr_hit && (addr == REG_CTRL);
    assign reload_evt = wr_hit && ((addr == REG_PLO) || (addr == REG_PHI));
    assign start_evt  = ctrl_wr && wdata[B_START];

    generate
        if (HAS_STARTSTOP) begin : g_ss
            assign stop_evt = ctrl_wr && wdata[B_STOP];
        end else begin : g_no_ss
            assign stop_evt = 1'b0;
        end
    endgenerate

    generate
        if (WRITABLE_PERIOD) begin : g_wper
            logic [PERIOD_W-1:0] period_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    period_q <= FIXED_PERIOD;
                end else if (reload_evt) begin
                    period_q <= reload_val;
                end
            end
            always_comb begin
                reload_val = period_q;
                if (addr == REG_PHI) begin
                    reload_val[PERIOD_W-1:HALF_W] = wdata;
                end else begin
                    reload_val[HALF_W-1:0] = wdata;
                end
            end
            assign period_val = period_q;
        end else begin : g_fper
            assign period_val = FIXED_PERIOD;
            assign reload_val = FIXED_PERIOD;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ito_q  <= 1'b0;
            cont_q <= 1'b0;
        end else if (ctrl_wr) begin
            ito_q  <= wdata[B_ITO];
            cont_q <= wdata[B_CONT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_q <= 1'b0;
        end else if (expire) begin
            to_q <= 1'b1;
        end else if (status_wr) begin
            to_q <= 1'b0;
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (reg_sel_e'(addr))
            REG_STATUS: begin
                rd_mux[B_TO]  = to_q;
                rd_mux[B_RUN] = running;
            end
            REG_CTRL: begin
                rd_mux[B_ITO]  = ito_q;
                rd_mux[B_CONT] = cont_q;
            end
            REG_PLO: rd_mux = period_val[HALF_W-1:0];
            REG_PHI: rd_mux = period_val[PERIOD_W-1:HALF_W];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (sel && !wr) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata   = rdata_q;
    assign ito     = ito_q;
    assign cont    = cont_q;
    assign to_flag = to_q;
    assign irq     = to_q && ito_q;
endmodule

// File: rtl/itimer_fsm.sv
module itimer_fsm
    import itimer_pkg::*;
#(
    parameter int unsigned        PERIOD_W      = 32,
    parameter bit                 HAS_STARTSTOP = 1'b1,
    parameter logic [PERIOD_W-1:0] RESET_COUNT  = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_evt,
    input  logic                stop_evt,
    input  logic                reload_evt,
    input  logic [PERIOD_W-1:0] reload_val,
    input  logic [PERIOD_W-1:0] period_val,
    input  logic                cont,
    output logic                running,
    output logic                expire,
    output logic [PERIOD_W-1:0] count
);
    localparam tmr_state_e RESET_ST = HAS_STARTSTOP ? ST_IDLE : ST_RUN;

    tmr_state_e          state_q, state_d;
    logic [PERIOD_W-1:0] count_q, count_d;
    logic                at_zero;

    assign at_zero = (state_q == ST_RUN) && (count_q == '0);
    assign expire  = at_zero && !reload_evt && !stop_evt;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_evt && !stop_evt) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (stop_evt)              state_d = ST_IDLE;
                else if (expire && !cont)  state_d = ST_IDLE;
            end
        endcase
        if (reload_evt && HAS_STARTSTOP) state_d = ST_IDLE;
    end

    always_comb begin
        count_d = count_q;
        if (reload_evt) begin
            count_d = reload_val;
        end else if ((state_q == ST_RUN) && !stop_evt) begin
            count_d = (count_q == '0) ? period_val : count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_ST;
            count_q <= RESET_COUNT;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        running = (state_q == ST_RUN);
        count   = count_q;
    end
endmodule

// File: rtl/itimer.sv
module itimer
    import itimer_pkg::*;
#(
    parameter int unsigned         HALF_W          = 16,
    parameter bit                  WRITABLE_PERIOD = 1'b1,
    parameter bit                  HAS_STARTSTOP   = 1'b1,
    parameter logic [2*HALF_W-1:0] FIXED_PERIOD    = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int unsigned PERIOD_W = 2 * HALF_W;

    logic [PERIOD_W-1:0] period_val, reload_val, count;
    logic ito, cont, start_evt, stop_evt, reload_evt, status_wr, to_flag;
    logic running, expire;

    itimer_regs #(
        .HALF_W(HALF_W), .WRITABLE_PERIOD(WRITABLE_PERIOD),
        .HAS_STARTSTOP(HAS_STARTSTOP), .FIXED_PERIOD(FIXED_PERIOD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
        .expire(expire), .running(running),
        .period_val(period_val), .reload_val(reload_val),
        .ito(ito), .cont(cont), .start_evt(start_evt), .stop_evt(stop_evt),
        .reload_evt(reload_evt), .status_wr(status_wr), .to_flag(to_flag),
        .irq(irq)
    );

    itimer_fsm #(
        .PERIOD_W(PERIOD_W), .HAS_STARTSTOP(HAS_STARTSTOP),
        .RESET_COUNT(FIXED_PERIOD)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .reload_evt(reload_evt), .reload_val(reload_val),
        .period_val(period_val), .cont(cont),
        .running(running), .expire(expire), .count(count)
    );
endmodule

// File: rtl/itimer_chk.sv
module itimer_chk #(
    parameter int unsigned PERIOD_W      = 32,
    parameter bit          HAS_STARTSTOP = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                expire,
    input logic                running,
    input logic                cont,
    input logic                ito,
    input logic                irq,
    input logic                to_flag,
    input logic                start_evt,
    input logic                stop_evt,
    input logic                reload_evt,
    input logic                status_wr,
    input logic [PERIOD_W-1:0] count,
    input logic [PERIOD_W-1:0] period_val
);
    p_to_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> to_flag);

    p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !cont |=> !running && (count == period_val));

    p_cont_rerun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire && cont |=> running);

    p_start_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        running && start_evt && !stop_evt && !reload_evt && (count != '0)
        |=> count == $past(count) - 1'b1);

    p_reload_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        HAS_STARTSTOP && reload_evt |=> !running && (count == period_val));

    p_free_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_STARTSTOP && running && !expire |=> running);

    p_stop_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !running);

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !start_evt && !reload_evt |=> $stable(count));

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ito && to_flag);

    p_status_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr && !expire |=> !to_flag);
endmodule

bind itimer itimer_chk #(
    .PERIOD_W(PERIOD_W), .HAS_STARTSTOP(HAS_STARTSTOP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .expire(expire), .running(running),
    .cont(cont), .ito(ito), .irq(irq), .to_flag(to_flag),
    .start_evt(start_evt), .stop_evt(stop_evt), .reload_evt(reload_evt),
    .status_wr(status_wr), .count(count), .period_val(period_val)
);

// File: tb/itimer_tb.sv
module itimer_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit          dut_b;
        logic [15:0] exp;
        string       tag;
    } rd_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        sel_a = 0, wr_a = 0, sel_b = 0, wr_b = 0;
    logic [1:0]  addr_a = 0, addr_b = 0;
    logic [15:0] wdata_a = 0, wdata_b = 0, rdata_a, rdata_b;
    logic        irq_a, irq_b;
    logic        iss_a = 0, iss_b = 0;

    int total = 0;
    int bad = 0;
    rd_item_t sb_q[$];

    itimer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(wr_a),
        .bus_addr(addr_a), .bus_wdata(wdata_a), .bus_rdata(rdata_a), .irq(irq_a)
    );

    itimer #(.WRITABLE_PERIOD(1'b0), .HAS_STARTSTOP(1'b0), .FIXED_PERIOD(32'd20)) u_dut_fx (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_wr(wr_b),
        .bus_addr(addr_b), .bus_wdata(wdata_b), .bus_rdata(rdata_b), .irq(irq_b)
    );

    always @(posedge clk) begin
        iss_a <= sel_a && !wr_a;
        iss_b <= sel_b && !wr_b;
    end

    // monitor: pops expected read items and compares
    always @(negedge clk) begin
        if (iss_a || iss_b) begin
            rd_item_t it;
            logic [15:0] act;
            total++;
            if (sb_q.size() == 0) begin
                bad++;
                $display("FAIL unexpected read data act=%h exp=none", iss_b ? rdata_b : rdata_a);
            end else begin
                it  = sb_q.pop_front();
                act = it.dut_b ? rdata_b : rdata_a;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle_bus();
        sel_a = 0; wr_a = 0; sel_b = 0; wr_b = 0;
    endtask

    task automatic wr_reg(input bit b, input logic [1:0] a, input logic [15:0] d);
        if (b) begin sel_b = 1; wr_b = 1; addr_b = a; wdata_b = d; end
        else   begin sel_a = 1; wr_a = 1; addr_a = a; wdata_a = d; end
        @(negedge clk);
        idle_bus();
    endtask

    task automatic rd_reg(input bit b, input logic [1:0] a, input logic [15:0] exp, input string tag);
        rd_item_t it;
        it.dut_b = b; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        if (b) begin sel_b = 1; wr_b = 0; addr_b = a; end
        else   begin sel_a = 1; wr_a = 0; addr_a = a; end
        @(negedge clk);
        idle_bus();
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input bit b, input logic exp, input string tag);
        logic act;
        act = b ? irq_b : irq_a;
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s irq act=%b exp=%b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // ---- fixed-period, free-running build ----
        rd_reg(1, 2'd0, 16'h0002, "R1 fixed build runs from reset");
        wait_n(30);
        rd_reg(1, 2'd0, 16'h0001, "R4 fixed build one-shot stopped");
        wr_reg(1, 2'd1, 16'h0007);          // ITO|CONT|START
        wr_reg(1, 2'd0, 16'h0000);          // clear TO
        wr_reg(1, 2'd2, 16'h0005);          // reload to constant 20, keep running
        wait_n(20);
        chk_irq(1, 1'b0, "R8 reload restarts full fixed period (before)");
        wait_n(1);
        chk_irq(1, 1'b1, "R9 reload uses fixed constant (at P+1)");
        wr_reg(1, 2'd1, 16'h000B);          // ITO|CONT|STOP: STOP ignored
        rd_reg(1, 2'd0, 16'h0003, "R8 STOP ignored without start/stop");
        rd_reg(1, 2'd2, 16'h0014, "R9 fixed period low reads constant");
        rd_reg(1, 2'd3, 16'h0000, "R9 fixed period high reads constant");
        rd_reg(1, 2'd1, 16'h0003, "R2 control reads ITO|CONT only");

        // ---- default build ----
        chk_irq(0, 1'b0, "R1 irq low after reset");
        rd_reg(0, 2'd0, 16'h0000, "R1 status after reset");
        rd_reg(0, 2'd1, 16'h0000, "R1 control after reset");
        rd_reg(0, 2'd2, 16'd100,  "R2 period low reset value");
        wr_reg(0, 2'd2, 16'd10);
        wr_reg(0, 2'd3, 16'd0);
        rd_reg(0, 2'd2, 16'd10,   "R2 period low readback");
        rd_reg(0, 2'd0, 16'h0000, "R7 period write leaves counter stopped");
        // R3 one-shot latency
        wr_reg(0, 2'd1, 16'h0005);          // ITO|START
        wait_n(10);
        chk_irq(0, 1'b0, "R3 no timeout at P edges");
        wait_n(1);
        chk_irq(0, 1'b1, "R3 timeout at P+1 edges");
        rd_reg(0, 2'd0, 16'h0001, "R4 one-shot stopped after expiry");
        wr_reg(0, 2'd0, 16'h0000);
        chk_irq(0, 1'b0, "R11 status write clears TO");
        // R5 continuous
        wr_reg(0, 2'd1, 16'h0007);          // ITO|CONT|START, edge e
        wait_n(10);
        chk_irq(0, 1'b0, "R5 first expiry not early");
        wait_n(1);
        chk_irq(0, 1'b1, "R5 first expiry");
        wr_reg(0, 2'd0, 16'h0000);          // clear at e+12
        chk_irq(0, 1'b0, "R11 clear while running");
        wait_n(9);
        chk_irq(0, 1'b0, "R5 second expiry not early");
        wait_n(1);
        chk_irq(0, 1'b1, "R5 second expiry after P+1");
        rd_reg(0, 2'd0, 16'h0003, "R5 still running after expiry");
        // R10 stop
        wr_reg(0, 2'd1, 16'h000B);          // ITO|CONT|STOP
        rd_reg(0, 2'd0, 16'h0001, "R10 STOP halts counter");
        wr_reg(0, 2'd0, 16'h0000);
        wait_n(15);
        chk_irq(0, 1'b0, "R10 no expiry while halted");
        // R6 start while running
        wr_reg(0, 2'd2, 16'd6);
        wr_reg(0, 2'd1, 16'h0007);          // start, edge s
        wait_n(3);
        wr_reg(0, 2'd1, 16'h0007);          // START again at s+4
        wait_n(2);
        chk_irq(0, 1'b0, "R6 no expiry before schedule");
        wait_n(1);
        chk_irq(0, 1'b1, "R6 expiry on original schedule");
        // R7 period write stops a running counter
        wr_reg(0, 2'd2, 16'd6);
        wr_reg(0, 2'd0, 16'h0000);
        wait_n(20);
        chk_irq(0, 1'b0, "R7 no expiry after period write");
        rd_reg(0, 2'd0, 16'h0000, "R7 period write stopped counter");
        // R10 STOP beats START
        wr_reg(0, 2'd1, 16'h000F);
        rd_reg(0, 2'd0, 16'h0000, "R10 STOP wins over START");
        rd_reg(0, 2'd1, 16'h0003, "R2 control readback ITO|CONT");
        // R11 irq needs ITO
        wr_reg(0, 2'd2, 16'd3);
        wr_reg(0, 2'd1, 16'h0006);          // CONT|START, no ITO
        wait_n(10);
        chk_irq(0, 1'b0, "R11 irq masked without ITO");
        rd_reg(0, 2'd0, 16'h0003, "R11 TO set while masked");
        wr_reg(0, 2'd1, 16'h0008);
        // R2 high half
        wr_reg(0, 2'd3, 16'd1);
        wr_reg(0, 2'd2, 16'd0);
        rd_reg(0, 2'd3, 16'd1, "R2 period high readback");
        rd_reg(0, 2'd2, 16'd0, "R2 period low readback zero");
        wr_reg(0, 2'd0, 16'h0000);
        wr_reg(0, 2'd1, 16'h0007);
        wait_n(50);
        rd_reg(0, 2'd0, 16'h0002, "R2 long period still counting");
        wait_n(3);
        total++;
        if (sb_q.size() != 0) begin
            bad++;
            $display("FAIL R2 pending reads act=%0d exp=0", sb_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule